// File: doc/BRIEF.md
# Narrow-to-Wide Bus Width Bridge

This bridge joins a host that issues 32-bit single-beat requests on a TileLink-UL style request/response pair to a device whose data path is 128 bits wide. Each request from the host becomes exactly one wide request. The address, opcode, size and source pass through unchanged. The 32-bit write data and its 4-bit byte mask are moved into the 32-bit lane that address bits [3:2] select. All other lanes carry zero data and a zero mask.

The bridge keeps one transaction in flight. It records the lane index of the accepted request. When the device answers, the bridge returns that lane of the 128-bit response data to the host. The response opcode, size, source and error pass through. The bridge computes fresh integrity codes for the wide command, for the wide write data and for the narrow response, using a byte-wise XOR fold.

Top module: `nw_bridge`

## Requirements
- R1: Each accepted host request produces exactly one device request in the same cycle. Its address, opcode (4 = Get, 0 = full write), size and source equal the host's values.
- R2: The host write data appears in wide data bits [32k+31:32k], where k = address[3:2]. Every other bit of the wide data is zero.
- R3: The 4-bit host mask appears in wide mask bits [4k+3:4k], where k = address[3:2]. The other 12 mask bits are zero.
- R4: From the cycle after a device request handshake until the host response handshake, the host ready output and the device request valid output are both 0.
- R5: The 32-bit host response data equals wide response bits [32k+31:32k], where k is the address[3:2] of the request in flight, registered when that request was accepted.
- R6: The host response opcode (0 = write acknowledge, 1 = acknowledge with data), size, source and error equal the device response values.
- R7: While no request is in flight, a device response is ignored: host response valid and device response ready both stay 0.
- R8: The command check byte is the XOR of the eight bytes of the 64-bit value {3'b0, opcode[2:0], size[1:0], source[7:0], address[31:0], mask[15:0]}, taken from the wide request.
- R9: The data check byte is the XOR of the sixteen bytes of the 128-bit wide write data.
- R10: The response check byte is the XOR of the six bytes of the 48-bit value {2'b0, opcode[2:0], size[1:0], source[7:0], error, data[31:0]}, taken from the host response.
- R11: After reset, no request is in flight. The host ready output follows the device ready input, and host response valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready |
| h_req_opcode | input | 3 | Host request opcode |
| h_req_size | input | 2 | Host request size (log2 bytes) |
| h_req_source | input | 8 | Host request source ID |
| h_req_addr | input | 32 | Host request address |
| h_req_mask | input | 4 | Host byte mask |
| h_req_data | input | 32 | Host write data |
| d_req_valid | output | 1 | Device request valid |
| d_req_ready | input | 1 | Device request ready |
| d_req_opcode | output | 3 | Device request opcode |
| d_req_size | output | 2 | Device request size |
| d_req_source | output | 8 | Device request source ID |
| d_req_addr | output | 32 | Device request address |
| d_req_mask | output | 16 | Device byte mask |
| d_req_data | output | 128 | Device write data |
| d_req_cmd_chk | output | 8 | Command check byte |
| d_req_data_chk | output | 8 | Write data check byte |
| d_rsp_valid | input | 1 | Device response valid |
| d_rsp_ready | output | 1 | Device response ready |
| d_rsp_opcode | input | 3 | Device response opcode |
| d_rsp_size | input | 2 | Device response size |
| d_rsp_source | input | 8 | Device response source ID |
| d_rsp_error | input | 1 | Device response error |
| d_rsp_data | input | 128 | Device response data |
| h_rsp_valid | output | 1 | Host response valid |
| h_rsp_ready | input | 1 | Host response ready |
| h_rsp_opcode | output | 3 | Host response opcode |
| h_rsp_size | output | 2 | Host response size |
| h_rsp_source | output | 8 | Host response source ID |
| h_rsp_error | output | 1 | Host response error |
| h_rsp_data | output | 32 | Host response data (selected lane) |
| h_rsp_chk | output | 8 | Host response check byte |

## Verification
The assertions assume the environment follows valid/ready rules. A host holds its request fields stable while valid is high. The device answers only a request it has accepted, and it returns the source of that request. The bench issues one request at a time and waits for its response before the next. It drives a device response only after the matching wide request has completed its handshake. It also drives one deliberately stray response while no request is in flight, which R7 permits. Addresses cover all four lanes, and both reads and writes are used.

// File: rtl/nwb_pkg.sv
package nwb_pkg;
    localparam int NARROW_W = 32;
    localparam int WIDE_W   = 128;
    localparam int LANES    = WIDE_W / NARROW_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int NSTRB_W  = NARROW_W / 8;
    localparam int WSTRB_W  = WIDE_W / 8;
    localparam int FOLD_W   = 256;

    typedef struct packed {
        logic              busy;
        logic [LANE_W-1:0] lane;
    } nwb_state_t;

    function automatic logic [7:0] fold8(input logic [FOLD_W-1:0] v);
        logic [7:0] acc;
        acc = '0;
        for (int i = 0; i < FOLD_W; i++) begin
            acc[i % 8] = acc[i % 8] ^ v[i];
        end
        return acc;
    endfunction
endpackage

// File: rtl/nwb_req_steer.sv
module nwb_req_steer
    import nwb_pkg::*;
(
    input  logic [LANE_W-1:0]   lane_sel,
    input  logic [NARROW_W-1:0] n_data,
    input  logic [NSTRB_W-1:0]  n_mask,
    output logic [WIDE_W-1:0]   w_data,
    output logic [WSTRB_W-1:0]  w_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = (lane_sel == LANE_W'(g));
        assign w_data[g*NARROW_W +: NARROW_W] = hit ? n_data : '0;
        assign w_mask[g*NSTRB_W +: NSTRB_W]   = hit ? n_mask : '0;
    end
endmodule

// File: rtl/nwb_rsp_pick.sv
module nwb_rsp_pick
    import nwb_pkg::*;
(
    input  logic [LANE_W-1:0]   lane_sel,
    input  logic [WIDE_W-1:0]   w_data,
    output logic [NARROW_W-1:0] n_data
);
    logic [NARROW_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lanes[g] = w_data[g*NARROW_W +: NARROW_W];
    end

    assign n_data = lanes[lane_sel];
endmodule

// File: rtl/nw_bridge.sv
module nw_bridge
    import nwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 8,
    parameter int OP_W   = 3,
    parameter int SIZE_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_req_valid,
    output logic                h_req_ready,
    input  logic [OP_W-1:0]     h_req_opcode,
    input  logic [SIZE_W-1:0]   h_req_size,
    input  logic [SRC_W-1:0]    h_req_source,
    input  logic [ADDR_W-1:0]   h_req_addr,
    input  logic [NSTRB_W-1:0]  h_req_mask,
    input  logic [NARROW_W-1:0] h_req_data,
    output logic                d_req_valid,
    input  logic                d_req_ready,
    output logic [OP_W-1:0]     d_req_opcode,
    output logic [SIZE_W-1:0]   d_req_size,
    output logic [SRC_W-1:0]    d_req_source,
    output logic [ADDR_W-1:0]   d_req_addr,
    output logic [WSTRB_W-1:0]  d_req_mask,
    output logic [WIDE_W-1:0]   d_req_data,
    output logic [7:0]          d_req_cmd_chk,
    output logic [7:0]          d_req_data_chk,
    input  logic                d_rsp_valid,
    output logic                d_rsp_ready,
    input  logic [OP_W-1:0]     d_rsp_opcode,
    input  logic [SIZE_W-1:0]   d_rsp_size,
    input  logic [SRC_W-1:0]    d_rsp_source,
    input  logic                d_rsp_error,
    input  logic [WIDE_W-1:0]   d_rsp_data,
    output logic                h_rsp_valid,
    input  logic                h_rsp_ready,
    output logic [OP_W-1:0]     h_rsp_opcode,
    output logic [SIZE_W-1:0]   h_rsp_size,
    output logic [SRC_W-1:0]    h_rsp_source,
    output logic                h_rsp_error,
    output logic [NARROW_W-1:0] h_rsp_data,
    output logic [7:0]          h_rsp_chk
);
    localparam int LANE_LSB = $clog2(NSTRB_W);

    nwb_state_t state_d, state_q;
    logic [LANE_W-1:0] req_lane;
    logic req_fire, rsp_fire;

    assign req_lane = h_req_addr[LANE_LSB +: LANE_W];

    // Request channel: pass-through while idle
    assign d_req_valid  = h_req_valid && !state_q.busy;
    assign h_req_ready  = d_req_ready && !state_q.busy;
    assign d_req_opcode = h_req_opcode;
    assign d_req_size   = h_req_size;
    assign d_req_source = h_req_source;
    assign d_req_addr   = h_req_addr;
    assign req_fire     = d_req_valid && d_req_ready;

    nwb_req_steer u_steer (
        .lane_sel (req_lane),
        .n_data   (h_req_data),
        .n_mask   (h_req_mask),
        .w_data   (d_req_data),
        .w_mask   (d_req_mask)
    );

    assign d_req_cmd_chk  = fold8(FOLD_W'({d_req_opcode, d_req_size, d_req_source,
                                           d_req_addr, d_req_mask}));
    assign d_req_data_chk = fold8(FOLD_W'(d_req_data));

    // Response channel: only open while a request is in flight
    assign h_rsp_valid  = d_rsp_valid && state_q.busy;
    assign d_rsp_ready  = h_rsp_ready && state_q.busy;
    assign h_rsp_opcode = d_rsp_opcode;
    assign h_rsp_size   = d_rsp_size;
    assign h_rsp_source = d_rsp_source;
    assign h_rsp_error  = d_rsp_error;
    assign rsp_fire     = h_rsp_valid && h_rsp_ready;

    nwb_rsp_pick u_pick (
        .lane_sel (state_q.lane),
        .w_data   (d_rsp_data),
        .n_data   (h_rsp_data)
    );

    assign h_rsp_chk = fold8(FOLD_W'({h_rsp_opcode, h_rsp_size, h_rsp_source,
                                      h_rsp_error, h_rsp_data}));

    always_comb begin
        state_d = state_q;
        if (req_fire) begin
            state_d.busy = 1'b1;
            state_d.lane = req_lane;
        end else if (rsp_fire) begin
            state_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_addr_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        d_req_valid |-> (d_req_addr == h_req_addr) && (d_req_source == h_req_source));

    assert_mask_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        d_req_valid |-> ((d_req_mask & ~(WSTRB_W'(h_req_mask) << (NSTRB_W * req_lane))) == '0));

    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid && d_req_ready) |=> (!d_req_valid && !h_req_ready));

    assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && $past(state_q.busy)) |-> $stable(state_q.lane));

    assert_rsp_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_rsp_valid |-> (h_rsp_source == d_rsp_source) && (h_rsp_error == d_rsp_error));

    assert_idle_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.busy |-> (!h_rsp_valid && !d_rsp_ready));
endmodule

// File: tb/nw_bridge_tb.sv
module nw_bridge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic h_req_valid, h_req_ready, d_req_valid, d_req_ready;
    logic [2:0] h_req_opcode, d_req_opcode, d_rsp_opcode, h_rsp_opcode;
    logic [1:0] h_req_size, d_req_size, d_rsp_size, h_rsp_size;
    logic [7:0] h_req_source, d_req_source, d_rsp_source, h_rsp_source;
    logic [31:0] h_req_addr, d_req_addr, h_req_data, h_rsp_data;
    logic [3:0] h_req_mask;
    logic [15:0] d_req_mask;
    logic [127:0] d_req_data, d_rsp_data;
    logic [7:0] d_req_cmd_chk, d_req_data_chk, h_rsp_chk;
    logic d_rsp_valid, d_rsp_ready, d_rsp_error, h_rsp_valid, h_rsp_ready, h_rsp_error;

    nw_bridge u_dut (.*);

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0]  addr;
        logic [15:0]  mask;
        logic [127:0] data;
        logic [2:0]   op;
        logic [7:0]   src;
    } wide_exp_t;
    typedef struct {
        logic [2:0]  op;
        logic [7:0]  src;
        logic        err;
        logic [31:0] data;
    } rsp_exp_t;

    wide_exp_t req_q[$];
    rsp_exp_t  rsp_q[$];

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xbytes(input logic [127:0] v, input int nbytes);
        logic [7:0] r = '0;
        for (int b = 0; b < nbytes; b++) r ^= v[8*b +: 8];
        return r;
    endfunction

    // Monitor: compares the wide request against the scoreboard
    task automatic mon_req();
        wide_exp_t e = req_q.pop_front();
        chk("R1 valid", 128'(d_req_valid), 1);
        chk("R1 addr", 128'(d_req_addr), 128'(e.addr));
        chk("R1 opcode", 128'(d_req_opcode), 128'(e.op));
        chk("R1 source", 128'(d_req_source), 128'(e.src));
        chk("R2 data lane", d_req_data, e.data);
        chk("R3 mask lane", 128'(d_req_mask), 128'(e.mask));
        chk("R8 cmd chk", 128'(d_req_cmd_chk),
            128'(xbytes(128'({3'b0, e.op, 2'd2, e.src, e.addr, e.mask}), 8)));
        chk("R9 data chk", 128'(d_req_data_chk), 128'(xbytes(e.data, 16)));
    endtask

    task automatic mon_rsp();
        rsp_exp_t e = rsp_q.pop_front();
        chk("R7 rsp valid", 128'(h_rsp_valid), 1);
        chk("R5 rsp lane data", 128'(h_rsp_data), 128'(e.data));
        chk("R6 opcode", 128'(h_rsp_opcode), 128'(e.op));
        chk("R6 source", 128'(h_rsp_source), 128'(e.src));
        chk("R6 error", 128'(h_rsp_error), 128'(e.err));
        chk("R10 rsp chk", 128'(h_rsp_chk),
            128'(xbytes(128'({2'b0, e.op, 2'd2, e.src, e.err, e.data}), 6)));
    endtask

    // Driver: one full transaction
    task automatic txn(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [3:0] m, input logic [7:0] src,
                       input logic [127:0] rd, input logic err);
        wide_exp_t we;
        rsp_exp_t  re;
        int k = int'(addr[3:2]);
        we.addr = addr; we.op = op; we.src = src;
        we.data = '0; we.data[32*k +: 32] = wd;
        we.mask = '0; we.mask[4*k +: 4] = m;
        req_q.push_back(we);
        re.op = (op == 3'd4) ? 3'd1 : 3'd0;
        re.src = src; re.err = err; re.data = rd[32*k +: 32];
        rsp_q.push_back(re);

        @(negedge clk);
        h_req_valid = 1; h_req_opcode = op; h_req_size = 2'd2; h_req_source = src;
        h_req_addr = addr; h_req_mask = m; h_req_data = wd; d_req_ready = 1;
        #1 mon_req();
        @(negedge clk);
        // host keeps valid high: bridge must stall it
        chk("R4 ready low", 128'(h_req_ready), 0);
        chk("R4 no second req", 128'(d_req_valid), 0);
        h_req_valid = 0;
        h_req_addr = 32'hFFFF_FFFC; // lane change must not alter response
        d_rsp_valid = 1; d_rsp_opcode = re.op; d_rsp_size = 2'd2; d_rsp_source = src;
        d_rsp_error = err; d_rsp_data = rd; h_rsp_ready = 1;
        #1 mon_rsp();
        @(negedge clk);
        d_rsp_valid = 0;
        chk("R4 idle again", 128'(h_req_ready), 1);
    endtask

    initial begin
        h_req_valid = 0; h_req_opcode = 0; h_req_size = 0; h_req_source = 0;
        h_req_addr = 0; h_req_mask = 0; h_req_data = 0; d_req_ready = 1;
        d_rsp_valid = 0; d_rsp_opcode = 0; d_rsp_size = 0; d_rsp_source = 0;
        d_rsp_error = 0; d_rsp_data = 0; h_rsp_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 ready follows", 128'(h_req_ready), 1);
        chk("R11 rsp valid", 128'(h_rsp_valid), 0);
        // stray response while idle
        d_rsp_valid = 1; d_rsp_data = {4{32'hA5A5_5A5A}};
        #1;
        chk("R7 stray valid", 128'(h_rsp_valid), 0);
        chk("R7 stray ready", 128'(d_rsp_ready), 0);
        @(negedge clk);
        d_rsp_valid = 0;
        txn(3'd0, 32'h0000_0000, 32'h1234_5678, 4'hF, 8'h01, '0, 1'b0);
        txn(3'd0, 32'h0003_0000, 32'hDEAD_BEEF, 4'hF, 8'h22, '0, 1'b0);
        txn(3'd4, 32'h0000_0008, 32'h0, 4'hF, 8'h03,
            128'h4444_4444_0000_0001_2222_2222_1111_1111, 1'b0);
        txn(3'd4, 32'h0000_0004, 32'h0, 4'h3, 8'h7E,
            128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 1'b1);
        txn(3'd0, 32'h4001_000C, 32'h99AA_BBCC, 4'h6, 8'hF0, '0, 1'b0);
        txn(3'd4, 32'h2000_001C, 32'h0, 4'hF, 8'h55,
            128'h0BAD_F00D_1357_9BDF_2468_ACE0_FEED_FACE, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule